// File: doc/BRIEF.md
# DMA Transfer Range Validity Checker

This block judges a DMA buffer request aimed at a legacy channel with a 24-bit address reach. A request gives a physical start address, a byte length and a channel number. The block answers one of three ways. The buffer can be used as it is. The buffer must be moved to a bounce buffer, because it reaches past the bus address space or crosses the channel's boundary window. Or the request cannot be honoured at all. Channels 0 to 3 move bytes and have a 64 KiB window. Channels 4 to 7 move 16-bit words and have a 128 KiB window.

The requester raises `start_i` for one cycle with the request on the inputs. One clock later `done_o` pulses and the two verdict flags become valid. The flags keep their value until the next request is evaluated. A new request may be presented in every cycle. Address translation, allocation and copying are done elsewhere.

Top module: `dma_range_chk`

## Requirements
- R1: After reset `done_o`, `bounce_o` and `illegal_o` are 0. `done_o` is 1 in exactly the cycle after each cycle in which `start_i` is 1, and 0 otherwise.
- R2: `bounce_o` and `illegal_o` change only in the cycle after a start. Between starts they keep the verdict of the last request.
- R3: On a byte channel (channel bit 2 = 0), a legal request whose first address and last address (start + length − 1) differ in any bit at position 16 or above sets `bounce_o`.
- R4: On a word channel (channel bit 2 = 1), the window is 128 KiB. Only a difference at bit 17 or above sets `bounce_o`, so a span across a 64 KiB line that stays inside one 128 KiB block does not bounce.
- R5: A legal request sets `bounce_o` when its start address or its last address is at or above 0x1000000. This includes the case where computing the last address carries past the top address bit.
- R6: On a byte channel a length above 65536 sets `illegal_o`. On a word channel a length above 131072 sets `illegal_o`. Lengths of exactly 65536 and 131072 are accepted.
- R7: A word-channel request with an odd start address (address bit 0 = 1) sets `illegal_o`.
- R8: A channel number with any bit above bit 2 set (a value of 8 or more on the 4-bit input) sets `illegal_o`.
- R9: A length of zero sets `illegal_o`.
- R10: When `illegal_o` is 1, `bounce_o` is 0.
- R11: A legal request that stays below 0x1000000 and inside one window gives `bounce_o` = 0 and `illegal_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Evaluate the request on the inputs in this cycle |
| addr_i | input | 32 | Physical start address |
| len_i | input | 20 | Transfer length in bytes |
| chan_i | input | 4 | Channel number; bit 2 selects word mode |
| done_o | output | 1 | One-cycle pulse: verdict valid |
| bounce_o | output | 1 | Request must use a bounce buffer |
| illegal_o | output | 1 | Request cannot be performed |

## Verification
The hardest case to produce is the carry out of the last-address sum, where start plus length wraps past the top of the 32-bit address. The bench drives it with a start address of 0xFFFFFFFF and one with 0xFFFFF0 near the 24-bit top. Other stimulus puts spans at exact window edges: a full 64 KiB block, a word span that crosses only a 64 KiB line, and lengths one past each maximum. These show that each channel type uses its own mask and limit. Back-to-back starts and idle gaps show that the verdict is refreshed only by a start.

// File: rtl/dma_rc_pkg.sv
package dma_rc_pkg;

  typedef struct packed {
    logic bounce;
    logic illegal;
  } rc_verdict_t;

  localparam int unsigned CHAN_LEGAL_W = 3;
  localparam int unsigned WORD_SEL_BIT = 2;

endpackage

// File: rtl/dma_rc_span.sv
module dma_rc_span #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 20,
  parameter int unsigned BUS_W      = 24,
  parameter int unsigned BYTE_WIN_W = 16,
  parameter int unsigned WORD_WIN_W = 17
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              word_i,
  output logic              out_of_reach_o,
  output logic              crosses_o
);

  localparam int unsigned SUM_W = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] HI_MASK   = {ADDR_W{1'b1}} << BUS_W;
  localparam logic [ADDR_W-1:0] BYTE_MASK = {ADDR_W{1'b1}} << BYTE_WIN_W;
  localparam logic [ADDR_W-1:0] WORD_MASK = {ADDR_W{1'b1}} << WORD_WIN_W;

  logic [SUM_W-1:0]  last_ext;
  logic [ADDR_W-1:0] diff;
  logic              byte_cross;
  logic              word_cross;

  // Last byte address, keeping the carry above the top address bit.
  always_comb begin
    last_ext = {1'b0, addr_i} + SUM_W'(len_i) - SUM_W'(1);
  end

  assign out_of_reach_o = (|(addr_i & HI_MASK)) |
                          (|(last_ext[ADDR_W-1:0] & HI_MASK)) |
                          last_ext[ADDR_W];

  assign diff       = addr_i ^ last_ext[ADDR_W-1:0];
  assign byte_cross = |(diff & BYTE_MASK);
  assign word_cross = |(diff & WORD_MASK);
  assign crosses_o  = word_i ? word_cross : byte_cross;

endmodule

// File: rtl/dma_rc_legal.sv
module dma_rc_legal #(
  parameter int unsigned LEN_W      = 20,
  parameter int unsigned CH_IN_W    = 4,
  parameter int unsigned BYTE_WIN_W = 16,
  parameter int unsigned WORD_WIN_W = 17
) (
  input  logic [LEN_W-1:0]   len_i,
  input  logic [CH_IN_W-1:0] chan_i,
  input  logic               addr_lsb_i,
  output logic               word_o,
  output logic               illegal_o
);
  import dma_rc_pkg::*;

  localparam logic [LEN_W-1:0] BYTE_MAX = LEN_W'(64'd1 << BYTE_WIN_W);
  localparam logic [LEN_W-1:0] WORD_MAX = LEN_W'(64'd1 << WORD_WIN_W);

  logic chan_bad;
  logic len_bad;
  logic align_bad;

  generate
    if (CH_IN_W > CHAN_LEGAL_W) begin : g_wide_chan
      assign chan_bad = |chan_i[CH_IN_W-1:CHAN_LEGAL_W];
    end else begin : g_exact_chan
      assign chan_bad = 1'b0;
    end
  endgenerate

  assign word_o    = chan_i[WORD_SEL_BIT];
  assign len_bad   = (len_i == '0) |
                     (word_o ? (len_i > WORD_MAX) : (len_i > BYTE_MAX));
  assign align_bad = word_o & addr_lsb_i;
  assign illegal_o = chan_bad | len_bad | align_bad;

endmodule

// File: rtl/dma_range_chk.sv
module dma_range_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LEN_W       = 20,
  parameter int unsigned CH_IN_W     = 4,
  parameter int unsigned BUS_W       = 24,
  parameter int unsigned BYTE_WIN_W  = 16,
  parameter int unsigned WORD_WIN_W  = 17,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [CH_IN_W-1:0] chan_i,
  output logic               done_o,
  output logic               bounce_o,
  output logic               illegal_o
);
  import dma_rc_pkg::*;

  // Reset: asserted at once, released through a synchroniser chain.
  logic [SYNC_STAGES-1:0] rst_chain;
  logic                   rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain <= '0;
    else        rst_chain <= {rst_chain[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ok = rst_chain[SYNC_STAGES-1];

  logic word_sel;
  logic illegal_c;
  logic reach_c;
  logic cross_c;

  dma_rc_legal #(
    .LEN_W(LEN_W), .CH_IN_W(CH_IN_W),
    .BYTE_WIN_W(BYTE_WIN_W), .WORD_WIN_W(WORD_WIN_W)
  ) u_legal (
    .len_i(len_i), .chan_i(chan_i), .addr_lsb_i(addr_i[0]),
    .word_o(word_sel), .illegal_o(illegal_c)
  );

  dma_rc_span #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_W(BUS_W),
    .BYTE_WIN_W(BYTE_WIN_W), .WORD_WIN_W(WORD_WIN_W)
  ) u_span (
    .addr_i(addr_i), .len_i(len_i), .word_i(word_sel),
    .out_of_reach_o(reach_c), .crosses_o(cross_c)
  );

  rc_verdict_t verdict_q, verdict_d;
  logic        done_q, done_d;
  logic        load_en;

  assign load_en = start_i;

  always_comb begin
    done_d    = start_i;
    verdict_d = verdict_q;
    if (load_en) begin
      verdict_d.illegal = illegal_c;
      verdict_d.bounce  = ~illegal_c & (reach_c | cross_c);
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      done_q    <= 1'b0;
      verdict_q <= '0;
    end else begin
      done_q    <= done_d;
      verdict_q <= verdict_d;
    end
  end

  assign done_o    = done_q;
  assign bounce_o  = verdict_q.bounce;
  assign illegal_o = verdict_q.illegal;

  // Assertions

  p_done_after_start_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    start_i |=> done_o);
  p_no_spurious_done_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    !start_i |=> !done_o);
  p_verdict_held_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    !start_i |=> ($stable(bounce_o) && $stable(illegal_o)));
  p_odd_word_illegal_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (start_i && chan_i[WORD_SEL_BIT] && addr_i[0]) |=> illegal_o);
  p_zero_len_illegal_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (start_i && len_i == '0) |=> illegal_o);
  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    !(bounce_o && illegal_o));

endmodule

// File: tb/dma_range_chk_test.sv
module dma_range_chk_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] addr_i;
  logic [19:0] len_i;
  logic [3:0]  chan_i;
  logic        done_o, bounce_o, illegal_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] last_exp = 2'b00;

  always #10 clk = ~clk;

  dma_range_chk uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .len_i(len_i), .chan_i(chan_i), .done_o(done_o),
    .bounce_o(bounce_o), .illegal_o(illegal_o)
  );

  // Reference verdict from the requirements: {bounce, illegal}
  function automatic logic [1:0] model(longint a, longint l, int c);
    bit ill, bnc;
    longint last;
    int win;
    ill = (c > 7) || (l == 0) ||
          ((c & 4) == 0 ? (l > 65536) : ((l > 131072) || (a % 2 == 1)));
    last = a + l - 1;
    win  = ((c & 4) != 0) ? 17 : 16;
    bnc  = !ill && ((a >= 64'h100_0000) || (last >= 64'h100_0000) ||
                    ((a >> win) != (last >> win)));
    return {bnc, ill};
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual bounce/illegal=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send(longint a, longint l, int c, string req);
    @(negedge clk);
    addr_i  = a[31:0];
    len_i   = l[19:0];
    chan_i  = c[3:0];
    start_i = 1'b1;
    exp_q.push_back(model(a, l, c));
    tag_q.push_back(req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  // Monitor: pops an expectation whenever a verdict is announced
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done_o) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R1: done pulse with no request, actual=1 expected=0");
        end else begin
          last_exp = exp_q.pop_front();
          check(tag_q.pop_front(), {bounce_o, illegal_o}, last_exp);
        end
      end
    end
  end

  initial begin
    start_i = 1'b0; addr_i = '0; len_i = '0; chan_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", {bounce_o, illegal_o}, 2'b00);
    check("R1 reset done", {1'b0, done_o}, 2'b00);
    rst_n = 1'b1;
    idle(4);

    send(64'h001000, 64'h1000, 1, "R11 small byte");
    send(64'h00FFF0, 64'h20, 0, "R3 byte cross 64K");
    send(64'h010000, 64'h10000, 2, "R6 R11 full 64K block");
    send(64'h020000, 64'h10001, 3, "R6 byte len over max");
    idle(1);
    send(64'h00FFF0, 64'h20, 5, "R4 word no cross at 64K");
    send(64'h01FFF0, 64'h20, 6, "R4 word cross 128K");
    send(64'h040000, 64'h20000, 4, "R6 word full 128K");
    send(64'h040000, 64'h20001, 4, "R6 word len over max");
    send(64'h001001, 64'h10, 7, "R7 odd word start");
    send(64'h001001, 64'h10, 3, "R7 odd byte start is fine");
    idle(3);
    // R2: verdict held during idle gap (last was legal: 00)
    check("R2 hold", {bounce_o, illegal_o}, last_exp);
    check("R1 no done when idle", {1'b0, done_o}, 2'b00);
    send(64'h001000, 64'h10, 8, "R8 channel 8");
    idle(4);
    check("R2 hold illegal", {bounce_o, illegal_o}, 2'b01);
    send(64'h001000, 64'h10, 12, "R8 channel 12");
    send(64'h001000, 64'h0, 1, "R9 zero length");
    send(64'h1000000, 64'h10, 0, "R5 start above bus");
    send(64'hFFFFF0, 64'h20, 3, "R5 last above bus");
    send(64'hFFFF00, 64'h100, 3, "R5 R11 ends at bus top");
    send(64'h2000000, 64'h10, 9, "R10 illegal masks bounce");
    send(64'hFFFFFFFF, 64'h2, 0, "R5 carry past top");
    send(64'hFFFFFFFE, 64'h10, 4, "R5 word carry past top");
    idle(4);
    check("R2 hold bounce", {bounce_o, illegal_o}, 2'b10);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R1: %0d verdicts missing, actual=0 expected=%0d", exp_q.size(), exp_q.size());
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule